// File: doc/BRIEF.md
# Banked Interrupt Identity Aggregator

The block gathers 16-bit event vectors from a set of engine sources and sorts them into two 32-bit pending banks. Each source sits in one of two banks at a fixed bit position. Sources are grouped in pairs, two sources to a pair. Each pair has a 32-bit enable register and a 32-bit mask register. The odd-numbered source of the pair uses the upper half of both registers, and the even-numbered source uses the lower half. An event bit is delivered only when its enable bit is 1 and its mask bit is 0. Delivered bits collect in a per-source accumulator, and the source's bank bit is set. A two-bit summary output shows which bank has a visible pending bit.

Software services a bank bit in four steps:
1. It writes a one-hot value to that bank's selector register.
2. It polls the bank's identity register until the valid flag rises. The flag rises a fixed number of cycles after the selector write. The identity carries the source's class (its pair index), its instance (position within the pair) and the accumulated event vector. An all-zero vector means nothing to service.
3. It writes the valid flag back, which acknowledges the identity and releases the accumulator.
4. It writes a one to the bank bit to clear it.

A clear on a bit whose handshake has not been completed is ignored. Reading a bank word freezes the visible copy of that word, and the summary bit taken from it, until the same word is written. Events that arrive in the meantime are held and show up after release.

The register port is a plain synchronous read/write port, with no back-pressure. A write takes effect at the clock edge where `bus_wr_i` is high. Read data appears on `bus_rdata_o` one cycle after `bus_rd_i`.

Address map (5-bit word address):

| Address | Register |
|---|---|
| 0x00 + b | Bank word b |
| 0x02 + b | Selector for bank b |
| 0x04 + b | Identity for bank b |
| 0x08 + p | Enable register of pair p |
| 0x10 + p | Mask register of pair p |

Global source g belongs to bank g / SRC_PER_BANK at bit g % SRC_PER_BANK, and to pair g / 2. SRC_PER_BANK must be even and no more than 8.

Top module: `irq_bank_aggr`

## Requirements
- R1: After reset every enable register reads 0 and every mask register reads 0xFFFFFFFF. Events on any source then set no bank bit, and `bank_sum_o` stays 0.
- R2: In a pair register, bits [31:16] belong to the odd source and bits [15:0] to the even source. An event bit sets the source's bank bit only if its enable bit is 1 and its mask bit is 0.
- R3: `bank_sum_o[b]` is 1 exactly when the visible copy of bank word b has any bit set.
- R4: A write to selector b starts an identity fetch only when the written value is one-hot within the bank's source bits and no fetch or unacknowledged identity is outstanding. The identity valid flag is bit 31 and rises ID_LAT cycles later (4 by default, never more than 64). Zero or multi-hot selector values are ignored.
- R5: The identity word holds the event vector in [15:0], the instance in [19:16] (global source index mod 2) and the class in [23:20] (pair index). Bits [30:24] are 0 and bit 31 is valid. While valid is set and no acknowledge arrives, the word does not change.
- R6: Selecting a bit with nothing pending returns an identity with valid set and an all-zero vector.
- R7: Writing identity b with bit 31 set clears its valid flag and marks the selected source as serviced.
- R8: A write-one-to-clear on a bank bit has no effect until that source has been serviced (R7). A permitted clear consumes the serviced state.
- R9: Reading bank word b freezes its visible value and `bank_sum_o[b]` until bank word b is written. Events that arrive meanwhile appear after the write.
- R10: Event bits for a source that arrive after its identity was captured accumulate into the next identity. After the clear, the bank bit stays set while such bits are held.
- R11: Read data appears on `bus_rdata_o` on the cycle after `bus_rd_i` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ev_i | input | 2*SRC_PER_BANK*16 | Per-source event bits, 16 per source, source g at [16g+15:16g] |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 5 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| bank_sum_o | output | 2 | Per-bank summary of the visible pending word |

## Verification
On every cycle, the assertions check four things:
- a bank bit never falls unless its source had been serviced;
- a locked bank word holds still until it is written;
- the identity valid flag only rises at the end of a fetch;
- an unacknowledged identity stays stable and drops right after acknowledgement.

Only the directed scenarios can show the rest. These include the half-word layout of the enable and mask pairs, the identity field values and their latency, the empty identity for a non-pending bit, the hand-off of late events into a second identity, and that events held during a lock surface after release.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int NBANK  = 2;
  localparam int EVW    = 16;
  localparam int AW     = 5;
  localparam int DW     = 32;
  localparam logic [AW-1:0] A_BANK = 5'h00;
  localparam logic [AW-1:0] A_SEL  = 5'h02;
  localparam logic [AW-1:0] A_ID   = 5'h04;
  localparam logic [AW-1:0] A_EN   = 5'h08;
  localparam logic [AW-1:0] A_MSK  = 5'h10;
  localparam int ID_VLD_BIT = 31;
endpackage

// File: rtl/irq_src_accum.sv
module irq_src_accum #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] msk_i,
  input  logic         take_i,
  output logic [W-1:0] acc_o,
  output logic         hit_o
);
  logic [W-1:0] gated;
  logic [W-1:0] acc_q;

  assign gated = ev_i & en_i & ~msk_i;
  assign hit_o = |gated;
  assign acc_o = acc_q;

  // a capture empties the accumulator, but bits arriving that cycle stay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= (take_i ? '0 : acc_q) | gated;
  end
endmodule

// File: rtl/irq_id_fetch.sv
module irq_id_fetch
  import irq_aggr_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int LAT  = 4,
  parameter int BANK = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sel_wr_i,
  input  logic [DW-1:0]            sel_i,
  input  logic                     ack_i,
  input  logic [NSRC-1:0][EVW-1:0] acc_i,
  output logic [DW-1:0]            id_o,
  output logic                     vld_o,
  output logic                     busy_o,
  output logic [NSRC-1:0]          take_o,
  output logic [NSRC-1:0]          ack_src_o
);
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int CW   = $clog2(LAT + 1);
  localparam int BASE = BANK * NSRC;

  logic          busy_q, vld_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q, sel_idx;
  logic [EVW-1:0] vec_q;
  logic          accept, fire;
  logic [3:0]    cls, inst;

  always_comb begin
    sel_idx = '0;
    for (int k = 0; k < NSRC; k++)
      if (sel_i[k]) sel_idx = IW'(k);
  end

  assign accept = sel_wr_i && !busy_q && !vld_q && $onehot(sel_i)
                  && ((sel_i >> NSRC) == '0);
  assign fire   = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      vec_q  <= '0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(LAT - 1);
        idx_q  <= sel_idx;
      end else if (fire) begin
        busy_q <= 1'b0;
        vld_q  <= 1'b1;
        vec_q  <= acc_i[idx_q];
      end else begin
        if (busy_q) cnt_q <= cnt_q - 1'b1;
        if (ack_i && vld_q) vld_q <= 1'b0;
      end
    end
  end

  always_comb begin
    cls  = 4'((BASE + int'(idx_q)) >> 1);
    inst = 4'((BASE + int'(idx_q)) & 1);
  end

  assign take_o    = fire ? (NSRC'(1) << idx_q) : '0;
  assign ack_src_o = (ack_i && vld_q) ? (NSRC'(1) << idx_q) : '0;
  assign vld_o     = vld_q;
  assign busy_o    = busy_q;
  assign id_o      = {vld_q, 7'd0, cls, inst, vec_q};
endmodule

// File: rtl/irq_bank_aggr.sv
module irq_bank_aggr
  import irq_aggr_pkg::*;
#(
  parameter int SRC_PER_BANK = 4,
  parameter int ID_LAT       = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NBANK*SRC_PER_BANK*EVW-1:0]   ev_i,
  input  logic                                bus_wr_i,
  input  logic                                bus_rd_i,
  input  logic [AW-1:0]                       bus_addr_i,
  input  logic [DW-1:0]                       bus_wdata_i,
  output logic [DW-1:0]                       bus_rdata_o,
  output logic [NBANK-1:0]                    bank_sum_o
);
  localparam int NSRC  = SRC_PER_BANK;
  localparam int NTOT  = NBANK * NSRC;
  localparam int NPAIR = NTOT / 2;

  logic [NPAIR-1:0][DW-1:0]            en_q, msk_q;
  logic [NBANK-1:0][NSRC-1:0]          pend_q, done_q, hit, take, ack_src, clr_ok, acc_nz;
  logic [NBANK-1:0][NSRC-1:0][EVW-1:0] acc;
  logic [NBANK-1:0][DW-1:0]            view_q, id_word;
  logic [NBANK-1:0]                    lock_q, bank_wr, bank_rd, sel_wr, ack, id_vld, id_busy;
  logic is_bank, is_sel, is_id, is_en, is_msk, pair_ok;
  logic [DW-1:0] rd_mux;

  // address decode
  assign is_bank = bus_addr_i[AW-1:1] == A_BANK[AW-1:1];
  assign is_sel  = bus_addr_i[AW-1:1] == A_SEL[AW-1:1];
  assign is_id   = bus_addr_i[AW-1:1] == A_ID[AW-1:1];
  assign is_en   = bus_addr_i[AW-1:3] == A_EN[AW-1:3];
  assign is_msk  = bus_addr_i[AW-1:3] == A_MSK[AW-1:3];
  assign pair_ok = int'(bus_addr_i[2:0]) < NPAIR;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_wr[b] = bus_wr_i && is_bank && (bus_addr_i[0] == b[0]);
    assign bank_rd[b] = bus_rd_i && is_bank && (bus_addr_i[0] == b[0]);
    assign sel_wr[b]  = bus_wr_i && is_sel  && (bus_addr_i[0] == b[0]);
    assign ack[b]     = bus_wr_i && is_id   && (bus_addr_i[0] == b[0])
                        && bus_wdata_i[ID_VLD_BIT];

    irq_id_fetch #(.NSRC(NSRC), .LAT(ID_LAT), .BANK(b)) u_fetch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_wr_i  (sel_wr[b]),
      .sel_i     (bus_wdata_i),
      .ack_i     (ack[b]),
      .acc_i     (acc[b]),
      .id_o      (id_word[b]),
      .vld_o     (id_vld[b]),
      .busy_o    (id_busy[b]),
      .take_o    (take[b]),
      .ack_src_o (ack_src[b])
    );

    assign bank_sum_o[b] = |view_q[b];
  end

  // one accumulator per source; pair p covers sources 2p (low half) and 2p+1 (high half)
  for (genvar g = 0; g < NTOT; g++) begin : g_src
    localparam int B = g / NSRC;
    localparam int I = g % NSRC;
    localparam int P = g / 2;
    localparam int H = g % 2;
    irq_src_accum #(.W(EVW)) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ev_i   (ev_i[g*EVW +: EVW]),
      .en_i   (en_q[P][H*EVW +: EVW]),
      .msk_i  (msk_q[P][H*EVW +: EVW]),
      .take_i (take[B][I]),
      .acc_o  (acc[B][I]),
      .hit_o  (hit[B][I])
    );
    assign acc_nz[B][I] = |acc[B][I];
  end

  always_comb begin
    for (int b = 0; b < NBANK; b++)
      clr_ok[b] = (bank_wr[b] ? bus_wdata_i[NSRC-1:0] : '0) & done_q[b];
  end

  // pending, serviced, lock and visible copy per bank
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      done_q <= '0;
      lock_q <= '0;
      view_q <= '0;
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        pend_q[b] <= (pend_q[b] & ~clr_ok[b]) | hit[b] | (clr_ok[b] & acc_nz[b]);
        done_q[b] <= (done_q[b] & ~clr_ok[b]) | ack_src[b];
        if (bank_wr[b])      lock_q[b] <= 1'b0;
        else if (bank_rd[b]) lock_q[b] <= 1'b1;
        if (!lock_q[b] && !bank_rd[b]) view_q[b] <= DW'(pend_q[b]);
      end
    end
  end

  // enable and mask registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      msk_q <= '1;
    end else if (bus_wr_i && pair_ok) begin
      if (is_en)  en_q[bus_addr_i[2:0]]  <= bus_wdata_i;
      if (is_msk) msk_q[bus_addr_i[2:0]] <= bus_wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (is_bank)               rd_mux = view_q[bus_addr_i[0]];
    else if (is_id)            rd_mux = id_word[bus_addr_i[0]];
    else if (is_en && pair_ok)  rd_mux = en_q[bus_addr_i[2:0]];
    else if (is_msk && pair_ok) rd_mux = msk_q[bus_addr_i[2:0]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/irq_bank_aggr_chk.sv
module irq_bank_aggr_chk #(
  parameter int NB   = 2,
  parameter int NSRC = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NB-1:0][NSRC-1:0]   pend_q,
  input logic [NB-1:0][NSRC-1:0]   done_q,
  input logic [NB-1:0]             lock_q,
  input logic [NB-1:0]             bank_wr,
  input logic [NB-1:0][31:0]       view_q,
  input logic [NB-1:0]             id_vld,
  input logic [NB-1:0]             id_busy,
  input logic [NB-1:0]             ack,
  input logic [NB-1:0][31:0]       id_word
);
  for (genvar b = 0; b < NB; b++) begin : g_b
    AST_VIEW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q[b] && !bank_wr[b]) |=> $stable(view_q[b])); // R9
    AST_VALID_FROM_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(id_vld[b]) |-> $past(id_busy[b])); // R4
    AST_ID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (id_vld[b] && !ack[b]) |=> $stable(id_word[b])); // R5
    AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (id_vld[b] && ack[b]) |=> !id_vld[b]); // R7
    for (genvar i = 0; i < NSRC; i++) begin : g_i
      AST_CLR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(pend_q[b][i]) |-> $past(done_q[b][i])); // R8
    end
  end
endmodule

bind irq_bank_aggr irq_bank_aggr_chk #(.NB(2), .NSRC(SRC_PER_BANK)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pend_q  (pend_q),
  .done_q  (done_q),
  .lock_q  (lock_q),
  .bank_wr (bank_wr),
  .view_q  (view_q),
  .id_vld  (id_vld),
  .id_busy (id_busy),
  .ack     (ack),
  .id_word (id_word)
);

// File: tb/irq_bank_aggr_tb.sv
module irq_bank_aggr_tb;
  localparam int SPB = 4;
  localparam int NT  = 2 * SPB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT*16-1:0] ev = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [4:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [1:0]    sum;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  irq_bank_aggr #(.SRC_PER_BANK(SPB), .ID_LAT(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ev_i(ev), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bank_sum_o(sum)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  // read a bank word, then release its lock without clearing anything
  task automatic peek_bank(input int b, output logic [31:0] d);
    bus_read(5'(b), d);
    bus_write(5'(b), 32'h0);
  endtask

  task automatic pulse(input int g, input logic [15:0] v);
    @(negedge clk); ev[g*16 +: 16] = v;
    @(negedge clk); ev[g*16 +: 16] = '0;
  endtask

  task automatic get_id(input int b, output logic [31:0] d);
    d = '0;
    for (int k = 0; k < 64; k++) begin
      bus_read(5'(4 + b), d);
      if (d[31]) break;
    end
  endtask

  task automatic service(input int b, input int bit_i, input logic [15:0] vec,
                         input logic [3:0] cls, input logic [3:0] inst);
    logic [31:0] d;
    bus_write(5'(2 + b), 32'h1 << bit_i);
    get_id(b, d);
    chk("R4 identity valid", {31'd0, d[31]}, 32'd1);
    chk("R5 identity fields", {8'd0, d[23:0]}, {8'd0, cls, inst, vec});
    bus_write(5'(4 + b), 32'h8000_0000);
    bus_read(5'(4 + b), d);
    chk("R7 valid cleared by ack", {31'd0, d[31]}, 32'd0);
    bus_read(5'(b), d);
    bus_write(5'(b), 32'h1 << bit_i);
    idle(2);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_read(5'h08, d); chk("R1 R11 enable reset", d, 32'h0);
    bus_read(5'h10, d); chk("R1 mask reset", d, 32'hFFFF_FFFF);
    chk("R1 summary reset", {30'd0, sum}, 32'd0);
    pulse(0, 16'hFFFF); pulse(5, 16'hFFFF); idle(3);
    peek_bank(0, d); chk("R1 no delivery bank0", d, 32'h0);
    chk("R1 summary quiet", {30'd0, sum}, 32'd0);
  endtask

  task automatic t_pairs;
    logic [31:0] d;
    bus_write(5'h08, 32'hFFFF_FFFF);
    bus_write(5'h10, 32'h0001_0000);
    pulse(1, 16'h0001); idle(3);
    peek_bank(0, d); chk("R2 masked upper bit", d, 32'h0);
    pulse(1, 16'h0002); idle(3);
    peek_bank(0, d); chk("R2 upper half delivered", d, 32'h2);
    bus_write(5'h09, 32'h0000_0004);
    bus_write(5'h11, 32'h0);
    pulse(2, 16'h0008); pulse(3, 16'hFFFF); idle(3);
    peek_bank(0, d); chk("R2 disabled bits", d, 32'h2);
    pulse(2, 16'h0004); idle(3);
    peek_bank(0, d); chk("R2 lower half delivered", d, 32'h6);
    service(0, 1, 16'h0002, 4'd0, 4'd1);
    service(0, 2, 16'h0004, 4'd1, 4'd0);
    peek_bank(0, d); chk("R8 cleared after service", d, 32'h0);
  endtask

  task automatic t_summary;
    bus_write(5'h0A, 32'h0000_FFFF);
    bus_write(5'h12, 32'h0);
    pulse(4, 16'h0020); idle(3);
    chk("R3 summary bank1", {30'd0, sum}, 32'd2);
    service(1, 0, 16'h0020, 4'd2, 4'd0);
    idle(2);
    chk("R3 summary cleared", {30'd0, sum}, 32'd0);
  endtask

  task automatic t_clear_gate;
    logic [31:0] d;
    pulse(0, 16'h0001); idle(3);
    bus_read(5'h00, d); chk("R8 pending seen", d, 32'h1);
    bus_write(5'h00, d); idle(2);
    peek_bank(0, d); chk("R8 early clear ignored", d, 32'h1);
    service(0, 0, 16'h0001, 4'd0, 4'd0);
    peek_bank(0, d); chk("R8 clear after ack", d, 32'h0);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    bus_read(5'h00, d); chk("R9 lock read", d, 32'h0);
    pulse(0, 16'h0004); idle(3);
    chk("R9 summary frozen", {30'd0, sum}, 32'd0);
    bus_read(5'h00, d); chk("R9 word frozen", d, 32'h0);
    bus_write(5'h00, 32'h0); idle(3);
    chk("R9 summary after release", {30'd0, sum}, 32'd1);
    peek_bank(0, d); chk("R9 held event appears", d, 32'h1);
    service(0, 0, 16'h0004, 4'd0, 4'd0);
  endtask

  task automatic t_accumulate;
    logic [31:0] d;
    pulse(0, 16'h0001); idle(2);
    bus_write(5'h02, 32'h1);
    get_id(0, d);
    chk("R10 first vector", {16'd0, d[15:0]}, 32'h1);
    pulse(0, 16'h0010); pulse(0, 16'h0100);
    bus_write(5'h04, 32'h8000_0000);
    bus_read(5'h00, d);
    bus_write(5'h00, 32'h1); idle(2);
    peek_bank(0, d); chk("R10 bit stays set", d, 32'h1);
    service(0, 0, 16'h0110, 4'd0, 4'd0);
  endtask

  task automatic t_empty;
    service(0, 3, 16'h0000, 4'd1, 4'd1); // R6
  endtask

  task automatic t_bad_sel;
    logic [31:0] d;
    bus_write(5'h02, 32'h3); idle(10);
    bus_read(5'h04, d); chk("R4 multi-hot ignored", {31'd0, d[31]}, 32'd0);
    bus_write(5'h02, 32'h0); idle(10);
    bus_read(5'h04, d); chk("R4 zero ignored", {31'd0, d[31]}, 32'd0);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_pairs();
    t_summary();
    t_clear_gate();
    t_lock();
    t_accumulate();
    t_empty();
    t_bad_sel();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule